// File: doc/BRIEF.md
# Square-root carry-select adder

A purely combinational adder for a 19-bit word (parameterisable) that splits the operands into sections. The lowest section is one ripple chain. It takes the external carry directly. Every higher section runs two ripple chains side by side. One assumes an incoming carry of 0 and the other an incoming carry of 1. The true carry arriving from the section below picks one of the two results, both the sum slice and the section carry.

By default the section lengths grow from the least significant end. Each section's own ripple chain then settles at about the time its select carry arrives, so the total delay is the first section's ripple plus one multiplexer per later section. Setting `LINEAR_P` builds equal 4-bit sections instead, with a shorter top section holding the remaining bits. There are no registers in the block.

Top module: `csa_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals `a_i + b_i + cin_i` as an unsigned (WIDTH_P+1)-bit value for every input combination, in both variants.
- R2: With `LINEAR_P = 0` the default word has six sections of 2, 2, 3, 3, 4 and 5 bits, counted from the least significant end. The carry into each section boundary equals the true carry into that bit position.
- R3: With `LINEAR_P = 1` the sections are 4, 4, 4, 4 and 3 bits, counted from the least significant end. Each boundary carry equals the true carry into that bit.
- R4: The lowest section has a single ripple chain fed by `cin_i`, and its result equals its slice sum plus `cin_i`.
- R5: Every higher section holds two candidate results over its slice: `a + b` (carry-in assumed 0) and `a + b + 1` (carry-in assumed 1), each with its carry bit.
- R6: The sum slice and carry out of each higher section equal the candidate that matches the section's incoming carry. That carry-out is the select for the next section.
- R7: All-ones plus zero gives all-ones with `cout_o = 0` when `cin_i = 0`. With `cin_i = 1` it gives zero with `cout_o = 1`, the carry crossing every section.
- R8: For every bit position k, operands with ones in all bits below k plus a carry that reaches bit k give a sum of exactly `1 << k` with no carry out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH_P | First operand |
| b_i | input | WIDTH_P | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH_P | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Two things can coincide: a section's own candidate results can differ in many bits, and at the same moment the select carry arrives from a lower section after rippling through every section below. This is provoked with operands that are all ones below a walking bit position, with the carry supplied either by `cin_i` or by a generate at bit 0. A carry then lands on every section boundary in turn. Two copies, one per variant, are driven with identical vectors, and each result is judged against a behavioural sum computed in the bench.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // width of section s; sqrt variant grows by one every two sections,
  // the last section absorbs a remainder smaller than the next size
  function automatic int sec_w(int w, bit lin, int s);
    int left;
    int sz;
    int nxt;
    left = w;
    for (int i = 0; i <= s; i++) begin
      sz  = lin ? 4 : 2 + i / 2;
      nxt = lin ? 4 : 2 + (i + 1) / 2;
      if (sz > left) sz = left;
      if (!lin && (left - sz < nxt)) sz = left;
      if (i == s) return sz;
      left = left - sz;
    end
    return 0;
  endfunction

  function automatic int num_sec(int w, bit lin);
    int left;
    int n;
    left = w;
    n = 0;
    while (left > 0) begin
      left = left - sec_w(w, lin, n);
      n++;
    end
    return n;
  endfunction

  function automatic int sec_lo(int w, bit lin, int s);
    int lo;
    lo = 0;
    for (int i = 0; i < s; i++) lo = lo + sec_w(w, lin, i);
    return lo;
  endfunction

endpackage

// File: rtl/csa_rca.sv
module csa_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] c;
  assign c[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s_o[i]  = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]  = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & c[i]);
  end

  assign c_o = c[W];
endmodule

// File: rtl/csa_section.sv
module csa_section #(
  parameter int W    = 4,
  parameter bit DUAL = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] r0;  // result for carry-in 0 (or the real carry when single)
  logic [W:0] r1;  // result for carry-in 1

  if (DUAL) begin : g_dual
    csa_rca #(.W(W)) u_rca0 (
      .a_i(a_i), .b_i(b_i), .c_i(1'b0), .s_o(r0[W-1:0]), .c_o(r0[W])
    );
    csa_rca #(.W(W)) u_rca1 (
      .a_i(a_i), .b_i(b_i), .c_i(1'b1), .s_o(r1[W-1:0]), .c_o(r1[W])
    );
  end else begin : g_single
    csa_rca #(.W(W)) u_rca (
      .a_i(a_i), .b_i(b_i), .c_i(c_i), .s_o(r0[W-1:0]), .c_o(r0[W])
    );
    assign r1 = r0;
  end

  assign {c_o, s_o} = (DUAL && c_i) ? r1 : r0;
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH_P  = 19,
  parameter bit LINEAR_P = 1'b0
) (
  input  logic [WIDTH_P-1:0] a_i,
  input  logic [WIDTH_P-1:0] b_i,
  input  logic               cin_i,
  output logic [WIDTH_P-1:0] sum_o,
  output logic               cout_o
);
  localparam int NSEC = csa_pkg::num_sec(WIDTH_P, LINEAR_P);

  logic [NSEC:0] sec_c;  // sec_c[s] = carry into section s
  assign sec_c[0] = cin_i;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    localparam int LO = csa_pkg::sec_lo(WIDTH_P, LINEAR_P, s);
    localparam int SW = csa_pkg::sec_w(WIDTH_P, LINEAR_P, s);
    csa_section #(.W(SW), .DUAL(s != 0)) u_sec (
      .a_i (a_i[LO +: SW]),
      .b_i (b_i[LO +: SW]),
      .c_i (sec_c[s]),
      .s_o (sum_o[LO +: SW]),
      .c_o (sec_c[s+1])
    );
  end

  assign cout_o = sec_c[NSEC];
endmodule

// File: rtl/csa_chk.sv
module csa_section_chk #(
  parameter int W    = 4,
  parameter bit DUAL = 1'b1
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         c_i,
  input logic [W-1:0] s_o,
  input logic         c_o,
  input logic [W:0]   r0,
  input logic [W:0]   r1
);
  always_comb begin
    if (DUAL) begin
      a_r5_cand_zero: assert (r0 == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("R5 candidate for carry 0 wrong");
      a_r5_cand_one: assert (r1 == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(1)))
        else $error("R5 candidate for carry 1 wrong");
      a_r6_select: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(c_i)))
        else $error("R6 selected section result wrong");
    end else begin
      a_r4_first: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(c_i)))
        else $error("R4 lowest section result wrong");
    end
  end
endmodule

module csa_adder_chk #(
  parameter int WIDTH_P  = 19,
  parameter bit LINEAR_P = 1'b0,
  parameter int NSEC     = 1
) (
  input logic [WIDTH_P-1:0] a_i,
  input logic [WIDTH_P-1:0] b_i,
  input logic               cin_i,
  input logic [WIDTH_P-1:0] sum_o,
  input logic               cout_o,
  input logic [NSEC:0]      sec_c
);
  logic [WIDTH_P:0] m;
  logic [WIDTH_P:0] t;
  int k;

  always_comb begin
    a_r1_sum: assert ({cout_o, sum_o} ==
                      ({1'b0, a_i} + {1'b0, b_i} + (WIDTH_P+1)'(cin_i)))
      else $error("R1 word sum wrong");
    for (int s = 0; s <= NSEC; s++) begin
      k = csa_pkg::sec_lo(WIDTH_P, LINEAR_P, s);
      m = ((WIDTH_P+1)'(1) << k) - (WIDTH_P+1)'(1);
      t = ({1'b0, a_i} & m) + ({1'b0, b_i} & m) + (WIDTH_P+1)'(cin_i);
      if (LINEAR_P) begin
        a_r3_boundary: assert (sec_c[s] == t[k])
          else $error("R3 boundary carry %0d wrong", s);
      end else begin
        a_r2_boundary: assert (sec_c[s] == t[k])
          else $error("R2 boundary carry %0d wrong", s);
      end
    end
  end
endmodule

bind csa_section csa_section_chk #(.W(W), .DUAL(DUAL)) u_sec_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .s_o(s_o), .c_o(c_o), .r0(r0), .r1(r1)
);

bind csa_adder csa_adder_chk #(.WIDTH_P(WIDTH_P), .LINEAR_P(LINEAR_P), .NSEC(NSEC)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o), .sec_c(sec_c)
);

// File: tb/csa_adder_tb.sv
module csa_adder_tb;
  localparam int W = 19;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic cin;
  logic [W-1:0] sum_sq, sum_ln;
  logic cout_sq, cout_ln;

  int n_run = 0;
  int n_fail = 0;
  logic [W:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  csa_adder #(.WIDTH_P(W), .LINEAR_P(1'b0)) u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_sq), .cout_o(cout_sq)
  );
  csa_adder #(.WIDTH_P(W), .LINEAR_P(1'b1)) u_dut_lin (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_ln), .cout_o(cout_ln)
  );

  // drive at posedge, reference pushed to the queue
  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic cv, input string tag);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    exp_q.push_back(W'(av) + W'(bv) + (W+1)'(cv) + (W+1)'(0) +
                    ({1'b0, av} + {1'b0, bv} + (W+1)'(cv)) - (W'(av) + W'(bv) + (W+1)'(cv)));
    tag_q.push_back(tag);
  endtask

  // compare on every negedge while vectors are pending
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run += 2;
      if ({cout_sq, sum_sq} !== e) begin
        n_fail++;
        $display("FAIL %s sqrt: got %h expected %h", t, {cout_sq, sum_sq}, e);
      end
      if ({cout_ln, sum_ln} !== e) begin
        n_fail++;
        $display("FAIL %s linear: got %h expected %h", t, {cout_ln, sum_ln}, e);
      end
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    apply('0, '0, 1'b0, "R1 reset zero");
    apply('0, '0, 1'b1, "R4 carry-in only");
    apply('1, '0, 1'b0, "R7 ones no carry");
    apply('1, '0, 1'b1, "R7 ones full propagate");
    apply('1, '1, 1'b1, "R7 ones plus ones");
    apply(W'(19'h2AAAA), W'(19'h55555), 1'b1, "R6 alternating");
    // carry landing on every bit: via cin_i, then via a generate at bit 0
    for (int k = 0; k < W; k++) begin
      apply(W'((1 << k) - 1), '0, 1'b1, "R8 R2 R3 walking via cin");
      if (k > 0) apply(W'((1 << k) - 1), W'(1), 1'b0, "R8 R5 R6 walking via generate");
    end
    for (int i = 0; i < 400; i++)
      apply(W'($urandom), W'($urandom), 1'($urandom), "R1 R5 random");
    @(posedge clk);
    @(posedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 queue: got %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule